// File: doc/BRIEF.md
# Buffered Serial Transmitter with Level Flag

This block turns parallel data words into asynchronous serial frames on a single line. Software pushes words through a one-cycle write strobe into a two-entry holding buffer. A shift engine pulls them out in write order and sends each as a frame whose length, parity and stop-bit count come from a configuration port. Bit timing comes from an external `bit_tick` strobe, and each bit stays on the line from one tick to the next.

A level flag tells software when it may write again. It reports an empty buffer, or, when the half-level select is set, a buffer holding at most one word. Command strobes turn the transmitter on and off and flush the buffer. A soft-reset strobe stops the line, disables the block and restores the frame configuration to its defaults. A write that finds the buffer full is lost and raises a sticky overflow flag.

Top module: `sertx_top`

## Requirements
- R1: After `rst` the line `tx_out` is 1, `busy` is 0, `tx_enabled` is 0, `level_flag` is 1 and `overflow` is 0.
- R2: A frame is a start bit of 0, then the data bits LSB first, then the parity bit if enabled, then the stop bits at 1. Each bit is held until the next `bit_tick`, and the line is 1 whenever no frame is in flight.
- R3: `cfg_len` sets 4 to 16 data bits. Any other code gives 8 bits, and 8 is the value after reset.
- R4: `cfg_parity` code 1 is odd, 2 is even, and 0 or 3 is none. With odd parity the count of ones over the data and parity bits is odd. With even parity that count is even.
- R5: `cfg_two_stop` = 1 gives two stop bits and 0 gives one.
- R6: The buffer holds two words, and frames leave in the order the words were written. Words written while the transmitter is disabled are kept until it is enabled.
- R7: With `cfg_half` = 0, `level_flag` is 1 exactly when the buffer is empty. With `cfg_half` = 1 it is 1 when at most one word is held. It follows a write or pop one cycle later.
- R8: A write to a full buffer is dropped and sets `overflow`. That flag stays set through clears and is cleared only by `rst` or `cmd_reset`.
- R9: `cmd_enable` turns the transmitter on and `cmd_disable` turns it off, and disable wins when both arrive in the same cycle. Disabling lets the frame in flight finish but starts no new one.
- R10: `cmd_clear` empties the buffer without cutting short the frame in flight. A write in the same cycle as a clear is kept as the only word.
- R11: `cmd_reset` aborts any frame, drives the line to 1, disables the transmitter, empties the buffer, clears `overflow` and restores 8 data bits, no parity, one stop bit and empty-level flagging. A write or configuration write in the same cycle is ignored.
- R12: The frame settings are captured when a frame starts. A configuration write during a frame affects only later frames.
- R13: When the shift engine takes a word from a full buffer in the same cycle as a write, the write is accepted and `overflow` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe marking each bit period |
| wr_en | input | 1 | Write strobe for the buffer |
| wr_data | input | 16 | Data word, LSB sent first |
| cmd_enable | input | 1 | Turn the transmitter on |
| cmd_disable | input | 1 | Turn the transmitter off |
| cmd_clear | input | 1 | Flush the buffer |
| cmd_reset | input | 1 | Soft reset of transmitter state and configuration |
| cfg_wr | input | 1 | Load the configuration fields below |
| cfg_len | input | 5 | Data bits per frame |
| cfg_parity | input | 2 | Parity code: 0 none, 1 odd, 2 even, 3 none |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_half | input | 1 | Flag at half level instead of empty |
| tx_out | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame is in flight |
| tx_enabled | output | 1 | Transmitter is enabled |
| level_flag | output | 1 | Buffer is at or below the selected level |
| overflow | output | 1 | Sticky lost-write flag |

## Verification
The collision that matters most is the shift engine taking a word from a full buffer in the same cycle that software writes a new one. A wrong implementation would drop that write and raise `overflow`. The bench fills the buffer while the transmitter is disabled, then times an enable so that the first pop lands on the edge that carries a write. It then checks that `overflow` stays low, that the flag still shows two words held, and that all three frames come out in order. A second collision, a clear and a write in the same cycle, is judged by which single frame is sent after the transmitter is enabled.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned MAX_BITS = 16;
  localparam int unsigned MIN_BITS = 4;
  localparam int unsigned DEF_BITS = 8;
  localparam int unsigned LEN_W    = $clog2(MAX_BITS + 1);

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_ODD  = 2'd1,
    PAR_EVEN = 2'd2
  } par_e;

  typedef struct packed {
    logic [LEN_W-1:0] nbits;
    par_e             par;
    logic             two_stop;
    logic             half_lvl;
  } frame_cfg_t;

  localparam frame_cfg_t CFG_DEFAULT = '{
    nbits:    LEN_W'(DEF_BITS),
    par:      PAR_NONE,
    two_stop: 1'b0,
    half_lvl: 1'b0
  };

  // Illegal lengths fall back to the default, unknown parity codes to none.
  function automatic frame_cfg_t decode_cfg(input logic [LEN_W-1:0] n,
                                            input logic [1:0] p,
                                            input logic s,
                                            input logic h);
    frame_cfg_t c;
    c.nbits = (n >= LEN_W'(MIN_BITS) && n <= LEN_W'(MAX_BITS)) ? n : LEN_W'(DEF_BITS);
    case (p)
      2'd1:    c.par = PAR_ODD;
      2'd2:    c.par = PAR_EVEN;
      default: c.par = PAR_NONE;
    endcase
    c.two_stop = s;
    c.half_lvl = h;
    return c;
  endfunction
endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_enable,
  input  logic             cmd_disable,
  input  logic             cmd_reset,
  input  logic             cfg_wr,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [1:0]       cfg_parity,
  input  logic             cfg_two_stop,
  input  logic             cfg_half,
  output frame_cfg_t       cfg_q,
  output logic             tx_en_q
);
  always_ff @(posedge clk) begin
    if (rst || cmd_reset) begin
      cfg_q   <= CFG_DEFAULT;
      tx_en_q <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= decode_cfg(cfg_len, cfg_parity, cfg_two_stop, cfg_half);
      if (cmd_disable)     tx_en_q <= 1'b0;
      else if (cmd_enable) tx_en_q <= 1'b1;
    end
  end

  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (rst)
    cmd_disable |=> !tx_en_q);  // R9
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.nbits >= LEN_W'(MIN_BITS)) && (cfg_q.nbits <= LEN_W'(MAX_BITS)));  // R3
  AST_SOFT_RESET_CFG: assert property (@(posedge clk) disable iff (rst)
    cmd_reset |=> (cfg_q == CFG_DEFAULT) && !tx_en_q);  // R11
endmodule

// File: rtl/sertx_buf.sv
module sertx_buf #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned W     = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         ovf_clr,
  input  logic         half_sel,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         level_flag,
  output logic         overflow
);
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW   = $clog2(DEPTH + 1);
  localparam int unsigned HALF = DEPTH / 2;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr, waddr;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          full, wr_ok, pop_ok;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign pop_ok = pop && !empty;
  assign wr_ok  = wr && (!full || pop_ok || flush);
  assign waddr  = flush ? '0 : wptr;
  assign rdata  = mem[rptr];

  always_comb begin
    if (flush) cnt_nxt = wr ? CW'(1) : '0;
    else       cnt_nxt = cnt + CW'(wr_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr       <= '0;
      rptr       <= '0;
      cnt        <= '0;
      level_flag <= 1'b1;
      overflow   <= 1'b0;
    end else begin
      cnt        <= cnt_nxt;
      level_flag <= half_sel ? (cnt_nxt <= CW'(HALF)) : (cnt_nxt == '0);
      if (flush) begin
        rptr <= '0;
        wptr <= wr ? adv('0) : '0;
      end else begin
        if (wr_ok)  wptr <= adv(wptr);
        if (pop_ok) rptr <= adv(rptr);
      end
      if (ovf_clr)          overflow <= 1'b0;
      else if (wr && !wr_ok) overflow <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));  // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (wr && full && !pop && !flush) |=> (cnt == CW'(DEPTH)) && overflow);  // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overflow && !ovf_clr) |=> overflow);  // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (flush && !wr) |=> empty);  // R10
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                abort,
  input  logic                bit_tick,
  input  logic                tx_en,
  input  logic                buf_empty,
  input  logic [MAX_BITS-1:0] rdata,
  input  frame_cfg_t          cfg,
  output logic                pop,
  output logic                tx_line,
  output logic                busy
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_e;

  st_e                 st;
  logic [MAX_BITS-1:0] sh;
  logic [LEN_W-1:0]    bcnt, nb_q;
  par_e                par_q;
  logic                two_q, stop2, pbit;

  function automatic logic calc_par(input logic [MAX_BITS-1:0] d,
                                    input logic [LEN_W-1:0] n,
                                    input par_e p);
    logic x;
    x = 1'b0;
    for (int i = 0; i < MAX_BITS; i++) begin
      if (LEN_W'(i) < n) x = x ^ d[i];
    end
    return (p == PAR_ODD) ? ~x : x;
  endfunction

  assign pop  = (st == S_IDLE) && tx_en && !buf_empty && !abort;
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st      <= S_IDLE;
      tx_line <= 1'b1;
      sh      <= '0;
      bcnt    <= '0;
      nb_q    <= LEN_W'(DEF_BITS);
      par_q   <= PAR_NONE;
      two_q   <= 1'b0;
      stop2   <= 1'b0;
      pbit    <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          tx_line <= 1'b1;
          if (pop) begin
            st      <= S_START;
            tx_line <= 1'b0;
            sh      <= rdata;
            nb_q    <= cfg.nbits;
            par_q   <= cfg.par;
            two_q   <= cfg.two_stop;
            pbit    <= calc_par(rdata, cfg.nbits, cfg.par);
          end
        end
        S_START: if (bit_tick) begin
          st      <= S_DATA;
          tx_line <= sh[0];
          sh      <= sh >> 1;
          bcnt    <= '0;
        end
        S_DATA: if (bit_tick) begin
          if (bcnt == nb_q - 1'b1) begin
            if (par_q != PAR_NONE) begin
              st      <= S_PAR;
              tx_line <= pbit;
            end else begin
              st      <= S_STOP;
              tx_line <= 1'b1;
              stop2   <= 1'b0;
            end
          end else begin
            tx_line <= sh[0];
            sh      <= sh >> 1;
            bcnt    <= bcnt + 1'b1;
          end
        end
        S_PAR: if (bit_tick) begin
          st      <= S_STOP;
          tx_line <= 1'b1;
          stop2   <= 1'b0;
        end
        S_STOP: if (bit_tick) begin
          if (two_q && !stop2) stop2 <= 1'b1;
          else                 st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> tx_line);  // R2
  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !tx_line);  // R2
  AST_DATA_COUNT: assert property (@(posedge clk) disable iff (rst)
    (st == S_DATA) |-> (bcnt < nb_q));  // R3
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
    (st == S_STOP) |-> tx_line);  // R5
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!busy && tx_line));  // R11
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_tick,
  input  logic                wr_en,
  input  logic [MAX_BITS-1:0] wr_data,
  input  logic                cmd_enable,
  input  logic                cmd_disable,
  input  logic                cmd_clear,
  input  logic                cmd_reset,
  input  logic                cfg_wr,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [1:0]          cfg_parity,
  input  logic                cfg_two_stop,
  input  logic                cfg_half,
  output logic                tx_out,
  output logic                busy,
  output logic                tx_enabled,
  output logic                level_flag,
  output logic                overflow
);
  frame_cfg_t          cfg_q;
  logic                pop, buf_empty, wr_eff, flush;
  logic [MAX_BITS-1:0] rdata;

  assign wr_eff = wr_en && !cmd_reset;
  assign flush  = cmd_clear || cmd_reset;

  sertx_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cmd_enable   (cmd_enable),
    .cmd_disable  (cmd_disable),
    .cmd_reset    (cmd_reset),
    .cfg_wr       (cfg_wr),
    .cfg_len      (cfg_len),
    .cfg_parity   (cfg_parity),
    .cfg_two_stop (cfg_two_stop),
    .cfg_half     (cfg_half),
    .cfg_q        (cfg_q),
    .tx_en_q      (tx_enabled)
  );

  sertx_buf #(.DEPTH(DEPTH), .W(MAX_BITS)) u_buf (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .ovf_clr    (cmd_reset),
    .half_sel   (cfg_q.half_lvl),
    .wr         (wr_eff),
    .wdata      (wr_data),
    .pop        (pop),
    .rdata      (rdata),
    .empty      (buf_empty),
    .level_flag (level_flag),
    .overflow   (overflow)
  );

  sertx_shift u_shift (
    .clk       (clk),
    .rst       (rst),
    .abort     (cmd_reset),
    .bit_tick  (bit_tick),
    .tx_en     (tx_enabled),
    .buf_empty (buf_empty),
    .rdata     (rdata),
    .cfg       (cfg_q),
    .pop       (pop),
    .tx_line   (tx_out),
    .busy      (busy)
  );

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!tx_enabled && !busy) |=> !busy);  // R9
endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_clear = 1'b0, cmd_reset = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [4:0]  cfg_len = 5'd8;
  logic [1:0]  cfg_parity = 2'd0;
  logic        cfg_two_stop = 1'b0, cfg_half = 1'b0;
  logic        tx_out, busy, tx_enabled, level_flag, overflow;

  int checks = 0;
  int errors = 0;
  logic exp_q[$];
  logic rx_q[$];
  int   tcnt = 0;
  int   cur_n = 8, cur_p = 0, cur_s = 0, cur_h = 0;
  int   mcnt = 0;
  bit   movf = 0;

  always #5 clk = ~clk;

  sertx_top u_dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_clear(cmd_clear),
    .cmd_reset(cmd_reset), .cfg_wr(cfg_wr), .cfg_len(cfg_len), .cfg_parity(cfg_parity),
    .cfg_two_stop(cfg_two_stop), .cfg_half(cfg_half), .tx_out(tx_out), .busy(busy),
    .tx_enabled(tx_enabled), .level_flag(level_flag), .overflow(overflow)
  );

  // Tick every third cycle; record the line bit that each tick closes.
  always @(negedge clk) begin
    logic tn;
    tn = (tcnt == 2);
    tcnt = (tcnt == 2) ? 0 : tcnt + 1;
    if (tn && busy) rx_q.push_back(tx_out);
    bit_tick = tn;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void push_frame(input logic [15:0] d);
    int n, ones;
    n = (cur_n >= 4 && cur_n <= 16) ? cur_n : 8;
    ones = 0;
    exp_q.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(d[i]);
      ones += int'(d[i]);
    end
    if (cur_p == 1) exp_q.push_back(((ones % 2) == 0) ? 1'b1 : 1'b0);
    if (cur_p == 2) exp_q.push_back(((ones % 2) == 1) ? 1'b1 : 1'b0);
    exp_q.push_back(1'b1);
    if (cur_s != 0) exp_q.push_back(1'b1);
  endfunction

  task automatic wr_word(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input bit en, input bit dis, input bit clr, input bit rs);
    @(negedge clk);
    cmd_enable = en; cmd_disable = dis; cmd_clear = clr; cmd_reset = rs;
    @(negedge clk);
    cmd_enable = 0; cmd_disable = 0; cmd_clear = 0; cmd_reset = 0;
    if (rs) begin cur_n = 8; cur_p = 0; cur_s = 0; cur_h = 0; end
  endtask

  task automatic set_cfg(input int n, input int p, input int s, input int h);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_len = 5'(n); cfg_parity = 2'(p); cfg_two_stop = s[0]; cfg_half = h[0];
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
    cur_n = n; cur_p = p; cur_s = s; cur_h = h;
  endtask

  task automatic wait_busy();
    while (!busy) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    int guard;
    bit ok;
    int bad;
    guard = 0;
    while (!((rx_q.size() >= exp_q.size()) && !busy) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (20) @(negedge clk);
    ok = (rx_q.size() == exp_q.size());
    bad = -1;
    if (ok) begin
      foreach (exp_q[i]) if (ok && rx_q[i] !== exp_q[i]) begin ok = 0; bad = i; end
    end
    if (!ok && bad >= 0)
      check(0, {tag, " bit mismatch at index shown"}, int'(rx_q[bad]), int'(exp_q[bad]));
    else
      check(ok, {tag, " frame bit count"}, rx_q.size(), exp_q.size());
    rx_q.delete();
    exp_q.delete();
  endtask

  initial begin
    logic [15:0] a, b, c;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values
    check(tx_out == 1'b1 && busy == 1'b0, "R1 line idle", int'({tx_out, busy}), 2);
    check(tx_enabled == 1'b0, "R1 disabled", int'(tx_enabled), 0);
    check(level_flag == 1'b1 && overflow == 1'b0, "R1 flags", int'({level_flag, overflow}), 2);

    // R2 R3 default 8N1 frame
    pulse(1, 0, 0, 0);
    push_frame(16'h00A5);
    wr_word(16'h00A5);
    drain("R2 R3 default frame");

    // R9 enable and disable together: disable wins
    pulse(1, 1, 0, 0);
    check(tx_enabled == 1'b0, "R9 disable wins", int'(tx_enabled), 0);

    // R9 disable mid-frame: frame finishes, next word held
    pulse(1, 0, 0, 0);
    push_frame(16'h0F3C);
    wr_word(16'h0F3C);
    wr_word(16'h0081);
    wait_busy();
    pulse(0, 1, 0, 0);
    drain("R9 frame in flight completes");
    check(level_flag == 1'b0, "R9 second word held while disabled", int'(level_flag), 0);
    push_frame(16'h0081);
    pulse(1, 0, 0, 0);
    drain("R6 held word sent after enable");

    // R12 configuration change during a frame
    push_frame(16'h00C3);
    wr_word(16'h00C3);
    wait_busy();
    set_cfg(4, 2, 1, 0);
    push_frame(16'h000B);
    wr_word(16'h000B);
    drain("R12 R4 R5 config captured at frame start");

    // R10 clear with simultaneous write
    pulse(0, 1, 0, 0);
    set_cfg(8, 1, 0, 0);
    wr_word(16'h0011);
    wr_word(16'h0022);
    @(negedge clk);
    cmd_clear = 1'b1; wr_en = 1'b1; wr_data = 16'h0055;
    @(negedge clk);
    cmd_clear = 1'b0; wr_en = 1'b0;
    check(level_flag == 1'b0, "R10 one word kept after clear", int'(level_flag), 0);
    check(overflow == 1'b0, "R10 clear plus write no overflow", int'(overflow), 0);
    push_frame(16'h0055);
    pulse(1, 0, 0, 0);
    drain("R10 only clear-cycle word sent");

    // R8 overflow sticky through clear
    pulse(0, 1, 0, 0);
    wr_word(16'h0001);
    wr_word(16'h0002);
    wr_word(16'h0003);
    check(overflow == 1'b1, "R8 overflow on full write", int'(overflow), 1);
    pulse(0, 0, 1, 0);
    check(overflow == 1'b1, "R8 overflow survives clear", int'(overflow), 1);
    check(level_flag == 1'b1, "R10 buffer empty after clear", int'(level_flag), 1);

    // R11 soft reset mid-frame
    set_cfg(5, 1, 1, 1);
    pulse(1, 0, 0, 0);
    wr_word(16'h001F);
    wait_busy();
    repeat (7) @(negedge clk);
    pulse(0, 0, 0, 1);
    check(tx_out == 1'b1 && busy == 1'b0, "R11 frame aborted", int'({tx_out, busy}), 2);
    check(tx_enabled == 1'b0, "R11 disabled", int'(tx_enabled), 0);
    check(level_flag == 1'b1 && overflow == 1'b0, "R11 flags reset", int'({level_flag, overflow}), 2);
    rx_q.delete();
    exp_q.delete();
    pulse(1, 0, 0, 0);
    push_frame(16'h013C);
    wr_word(16'h013C);
    drain("R11 default config restored");

    // R13 pop and write on the same edge with a full buffer
    set_cfg(6, 0, 0, 1);
    pulse(0, 1, 0, 0);
    a = 16'h002A; b = 16'h0015; c = 16'h0033;
    push_frame(a); push_frame(b); push_frame(c);
    wr_word(a);
    wr_word(b);
    check(level_flag == 1'b0, "R7 half level with two words", int'(level_flag), 0);
    @(negedge clk);
    cmd_enable = 1'b1;
    @(negedge clk);
    cmd_enable = 1'b0; wr_en = 1'b1; wr_data = c;
    @(negedge clk);
    wr_en = 1'b0;
    check(overflow == 1'b0, "R13 write with pop accepted", int'(overflow), 0);
    check(level_flag == 1'b0, "R13 two words still held", int'(level_flag), 0);
    drain("R13 R6 three frames in order");

    // Random configurations and bursts
    for (int it = 0; it < 40; it++) begin
      int n, p, s, h, k;
      logic [15:0] d;
      n = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 31) : $urandom_range(4, 16);
      p = $urandom_range(0, 3);
      s = $urandom_range(0, 1);
      h = $urandom_range(0, 1);
      pulse(0, 1, 0, 0);
      set_cfg(n, p, s, h);
      mcnt = 0;
      movf = 0;
      k = $urandom_range(1, 3);
      for (int j = 0; j < k; j++) begin
        d = 16'($urandom);
        wr_word(d);
        if (mcnt < 2) begin push_frame(d); mcnt++; end
        else movf = 1;
        check(level_flag == ((cur_h != 0) ? (mcnt <= 1) : (mcnt == 0)),
              "R7 level flag after write", int'(level_flag),
              int'((cur_h != 0) ? (mcnt <= 1) : (mcnt == 0)));
        check(overflow == movf, "R8 overflow model", int'(overflow), int'(movf));
      end
      pulse(1, 0, 0, 0);
      drain("R2 R3 R4 R5 random frames");
      if (movf) begin
        pulse(0, 0, 0, 1);
        check(overflow == 1'b0, "R11 overflow cleared by reset", int'(overflow), 0);
      end
    end

    summary();
    $finish;
  end
endmodule